// File: doc/BRIEF.md
# Superframe Maintenance Bit Update Latch

This block keeps the maintenance-channel bits that a line transmitter sends in every superframe: an 8-bit group for the fourth maintenance channel and a 4-bit auxiliary group. The auxiliary group carries the two fifth-channel bits, the one sixth-channel bit and one spare. The host may write the shadow copies at any moment. The framer only ever sees the active copy. The active copy takes the shadow values at a transmit superframe boundary, and only while the update-disable input is low. The error-indication, embedded-operations and CRC fields pass straight through, and the disable input does not touch them.

The host uses the disable input to stage a clean shutdown. It raises update-disable, writes the new fourth-channel bits, then lowers update-disable and raises the deactivation request in the same cycle. The next boundary loads the staged data. After three complete superframes of that data, the block raises a tear-down indication. Dropping the request before the last of those boundaries cancels the countdown.

Top module: `sfmMaintLatch`

## Requirements
- R1: After reset, m4Out is 8'hFF, auxOut is 4'hF, both shadow copies are all ones and tearDown is 0.
- R2: A shadow write (wrM4 takes wrData[7:0]; wrAux takes wrData[7:4]) does not change m4Out or auxOut in a cycle without a boundary strobe.
- R3: On a clock edge with sfBoundary=1 and updDisable=0, m4Out and auxOut take the shadow values, and the new values are visible after that edge.
- R4: On a boundary with updDisable=1, m4Out and auxOut keep their previous values, even when the shadow copies differ.
- R5: A shadow write in the same cycle as a loading boundary is the value that is loaded.
- R6: eocOut, febeOut and crcOut equal eocIn, febeIn and crcIn in the same cycle, whatever updDisable is.
- R7: tearDown rises after the fourth boundary edge seen while deactReq is continuously 1 (the first loads the data, three full superframes follow). It stays 1 while deactReq stays 1.
- R8: deactReq=0 on an edge clears the countdown, and tearDown is 0 in the following cycle.
- R9: For an auxiliary write only wrData[7:4] matters; wrData[3:0] has no effect on auxOut.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rstN | input | 1 | active-low synchronous reset |
| wrM4 | input | 1 | write the fourth-channel shadow from wrData |
| wrAux | input | 1 | write the auxiliary shadow from wrData[7:4] |
| wrData | input | 8 | host write data |
| sfBoundary | input | 1 | one-cycle transmit superframe boundary strobe |
| updDisable | input | 1 | freeze the active copy |
| deactReq | input | 1 | deactivation request level |
| eocIn | input | 12 | embedded-operations bits in |
| febeIn | input | 1 | far-end block error bit in |
| crcIn | input | 12 | CRC bits in |
| m4Out | output | 8 | active fourth-channel bits |
| auxOut | output | 4 | active fifth/sixth-channel bits and spare |
| eocOut | output | 12 | embedded-operations bits out |
| febeOut | output | 1 | far-end block error bit out |
| crcOut | output | 12 | CRC bits out |
| tearDown | output | 1 | three staged superframes have been sent |

## Verification
The bench aims at a write that lands on the same edge as the boundary strobe. A design that loaded the stale shadow there would send old data for a whole superframe. It also toggles update-disable across boundaries while the shadow copies change. A design that ignored the freeze would leak half-staged bits onto the line. The tear-down countdown is run to completion and aborted one boundary short. A miscounted window would shut the line down a superframe early or late, and a missing abort would tear down a link the host had chosen to keep.

// File: rtl/sfm_pkg.sv
package sfm_pkg;
  typedef struct packed {
    logic loadActive;   // copy shadow to active this edge
    logic allowUpdate;  // update not frozen (for guards)
  } ctlStrobes_t;
endpackage

// File: rtl/sfmMaintCtl.sv
module sfmMaintCtl
  import sfm_pkg::*;
#(
  parameter int TEAR_SF = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sfBoundary,
  input  logic        updDisable,
  input  logic        deactReq,
  output ctlStrobes_t strobes,
  output logic        tearDown
);
  localparam int LIMIT = TEAR_SF + 1;
  localparam int CW    = $clog2(LIMIT + 1);

  logic [CW-1:0] sfCount;

  always_comb begin
    strobes.allowUpdate = !updDisable;
    strobes.loadActive  = sfBoundary && !updDisable;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sfCount <= '0;
    end else if (!deactReq) begin
      sfCount <= '0;
    end else if (sfBoundary && (sfCount != CW'(LIMIT))) begin
      sfCount <= sfCount + 1'b1;
    end
  end

  assign tearDown = (sfCount == CW'(LIMIT));

  p_teardown_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(tearDown) |-> ($past(sfBoundary) && $past(deactReq)));

  p_abort_r8: assert property (@(posedge clk) disable iff (!rstN)
    !deactReq |=> !tearDown);
endmodule

// File: rtl/sfmMaintPath.sv
module sfmMaintPath
  import sfm_pkg::*;
#(
  parameter int M4_W   = 8,
  parameter int AUX_W  = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobes,
  input  logic              wrM4,
  input  logic              wrAux,
  input  logic [DATA_W-1:0] wrData,
  output logic [M4_W-1:0]   m4Out,
  output logic [AUX_W-1:0]  auxOut
);
  localparam int AUX_LO = DATA_W - AUX_W;

  logic [M4_W-1:0]  shadowM4,  nextM4;
  logic [AUX_W-1:0] shadowAux, nextAux;

  always_comb begin
    nextM4  = wrM4  ? wrData[M4_W-1:0]       : shadowM4;
    nextAux = wrAux ? wrData[DATA_W-1:AUX_LO] : shadowAux;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadowM4  <= '1;
      shadowAux <= '1;
      m4Out     <= '1;
      auxOut    <= '1;
    end else begin
      shadowM4  <= nextM4;
      shadowAux <= nextAux;
      if (strobes.loadActive) begin
        m4Out  <= nextM4;
        auxOut <= nextAux;
      end
    end
  end

  p_load_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadActive |=> (m4Out == $past(nextM4)) && (auxOut == $past(nextAux)));

  p_same_cycle_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.loadActive && wrM4) |=> (m4Out == $past(wrData[M4_W-1:0])));
endmodule

// File: rtl/sfmMaintLatch.sv
module sfmMaintLatch
  import sfm_pkg::*;
#(
  parameter int M4_W    = 8,
  parameter int AUX_W   = 4,
  parameter int DATA_W  = 8,
  parameter int EOC_W   = 12,
  parameter int CRC_W   = 12,
  parameter int TEAR_SF = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrM4,
  input  logic              wrAux,
  input  logic [DATA_W-1:0] wrData,
  input  logic              sfBoundary,
  input  logic              updDisable,
  input  logic              deactReq,
  input  logic [EOC_W-1:0]  eocIn,
  input  logic              febeIn,
  input  logic [CRC_W-1:0]  crcIn,
  output logic [M4_W-1:0]   m4Out,
  output logic [AUX_W-1:0]  auxOut,
  output logic [EOC_W-1:0]  eocOut,
  output logic              febeOut,
  output logic [CRC_W-1:0]  crcOut,
  output logic              tearDown
);
  ctlStrobes_t strobes;

  sfmMaintCtl #(.TEAR_SF(TEAR_SF)) uCtl (
    .clk(clk), .rstN(rstN), .sfBoundary(sfBoundary), .updDisable(updDisable),
    .deactReq(deactReq), .strobes(strobes), .tearDown(tearDown)
  );

  sfmMaintPath #(.M4_W(M4_W), .AUX_W(AUX_W), .DATA_W(DATA_W)) uPath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrM4(wrM4), .wrAux(wrAux),
    .wrData(wrData), .m4Out(m4Out), .auxOut(auxOut)
  );

  // ungated fields
  assign eocOut  = eocIn;
  assign febeOut = febeIn;
  assign crcOut  = crcIn;

  p_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (sfBoundary && updDisable) |=> ($stable(m4Out) && $stable(auxOut)));

  p_no_boundary_r2: assert property (@(posedge clk) disable iff (!rstN)
    !sfBoundary |=> ($stable(m4Out) && $stable(auxOut)));
endmodule

// File: tb/sfmMaintLatch_test.sv
`timescale 1ns/1ps
module sfmMaintLatch_test;
  logic clk = 0;
  logic rstN = 0;
  logic wrM4 = 0, wrAux = 0, sfBoundary = 0, updDisable = 0, deactReq = 0, febeIn = 0;
  logic [7:0] wrData = 0;
  logic [11:0] eocIn = 0, crcIn = 0;
  logic [7:0] m4Out;
  logic [3:0] auxOut;
  logic [11:0] eocOut, crcOut;
  logic febeOut, tearDown;

  int total = 0, bad = 0;
  logic [7:0] shM4, acM4;
  logic [3:0] shAux, acAux;
  int cnt;

  always #5 clk = ~clk;

  sfmMaintLatch uut (
    .clk(clk), .rstN(rstN), .wrM4(wrM4), .wrAux(wrAux), .wrData(wrData),
    .sfBoundary(sfBoundary), .updDisable(updDisable), .deactReq(deactReq),
    .eocIn(eocIn), .febeIn(febeIn), .crcIn(crcIn), .m4Out(m4Out), .auxOut(auxOut),
    .eocOut(eocOut), .febeOut(febeOut), .crcOut(crcOut), .tearDown(tearDown)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int expTear(input int c);
    return (c == 4) ? 1 : 0;
  endfunction

  task automatic checkState(input string tag);
    check(m4Out == acM4, tag, m4Out, acM4);
    check(auxOut == acAux, tag, auxOut, acAux);
    check(tearDown == expTear(cnt), {tag, " R7 tearDown"}, tearDown, expTear(cnt));
  endtask

  // apply inputs at negedge, update model for the coming edge, step to next negedge
  task automatic step(input bit w4, input bit wa, input logic [7:0] d,
                      input bit sb, input bit dis, input bit dr);
    logic [7:0] n4;
    logic [3:0] na;
    wrM4 = w4; wrAux = wa; wrData = d; sfBoundary = sb; updDisable = dis; deactReq = dr;
    eocIn = 12'($urandom); crcIn = 12'($urandom); febeIn = 1'($urandom);
    #1;
    check(eocOut == eocIn && crcOut == crcIn && febeOut == febeIn,
          "R6 pass-through", {eocOut, crcOut}, {eocIn, crcIn});
    n4 = w4 ? d : shM4;
    na = wa ? d[7:4] : shAux;
    shM4 = n4; shAux = na;
    if (sb && !dis) begin acM4 = n4; acAux = na; end
    if (!dr) cnt = 0;
    else if (sb && cnt < 4) cnt++;
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    shM4 = 8'hFF; acM4 = 8'hFF; shAux = 4'hF; acAux = 4'hF; cnt = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    checkState("R1 reset");

    // R2: write without boundary leaves active untouched
    step(1, 1, 8'h3C, 0, 0, 0);
    checkState("R2 write no boundary");
    // R1: shadow reset value was all ones -> now shows after boundary with no write? load staged 3C
    step(0, 0, 8'h00, 1, 0, 0);
    checkState("R3 boundary load");
    // R9: aux low nibble ignored
    step(0, 1, 8'h5A, 1, 0, 0);
    checkState("R9 aux upper nibble");
    check(auxOut == 4'h5, "R9 aux value", auxOut, 4'h5);
    // R5: same-cycle write
    step(1, 0, 8'hA7, 1, 0, 0);
    check(m4Out == 8'hA7, "R5 same-cycle write", m4Out, 8'hA7);
    // R4: frozen
    step(1, 1, 8'h11, 1, 1, 0);
    check(m4Out == 8'hA7, "R4 freeze holds", m4Out, 8'hA7);
    checkState("R4 freeze");

    // deactivation sequence R7
    step(1, 0, 8'hC3, 0, 1, 0);
    step(0, 0, 8'h00, 0, 0, 1);
    for (int i = 0; i < 4; i++) begin
      check(tearDown == 0, "R7 early tearDown", tearDown, 0);
      step(0, 0, 8'h00, 1, 0, 1);
      step(0, 0, 8'h00, 0, 0, 1);
    end
    check(tearDown == 1, "R7 tearDown after three superframes", tearDown, 1);
    check(m4Out == 8'hC3, "R7 staged data sent", m4Out, 8'hC3);
    step(0, 0, 8'h00, 0, 0, 1);
    check(tearDown == 1, "R7 tearDown held", tearDown, 1);
    // R8 abort one boundary short
    step(0, 0, 8'h00, 0, 0, 0);
    check(tearDown == 0, "R8 cleared", tearDown, 0);
    for (int i = 0; i < 3; i++) step(0, 0, 8'h00, 1, 0, 1);
    step(0, 0, 8'h00, 0, 0, 0);
    step(0, 0, 8'h00, 1, 0, 1);
    check(tearDown == 0, "R8 abort restarts count", tearDown, 0);
    checkState("R8 abort");
    step(0, 0, 8'h00, 0, 0, 0);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      step(1'($urandom % 3 == 0), 1'($urandom % 4 == 0), 8'($urandom),
           1'($urandom % 4 == 0), 1'($urandom % 3 == 0), 1'($urandom % 8 != 0));
      checkState("R3 R4 R5 random");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule